// File: doc/BRIEF.md
# Instruction Cycle Timing Sequencer

This block is the control sequencer of a 16-bit, single-accumulator, stored-program processor. A sequence counter steps through numbered time slots. Each slot is presented as one line of a one-hot timing vector. From the current slot and the instruction word, the block derives the control strobes for three phases: instruction fetch, decode, and resolution of an indirect operand address. The strobes are address-register load, instruction-register load, program-counter increment and memory read, together with a three-bit source select for the shared data bus.

The three opcode bits of the instruction word are decoded into eight select lines. A mode flip-flop captures the indirect flag during decode. In the slot after decode, the block tells the execution units which class the word belongs to: memory-reference, register-reference or input-output. The execution units own every slot from the fifth onward. They return an end-of-instruction request that starts the next fetch, or a halt request that freezes the sequencer until it is started again. All pins are plain level control signals. There is no streaming interface, so no handshake applies.

Top module: `instr_cycle_sequencer`

## Requirements
- R1: After reset, and until `start` is sampled high, `t_slot` is all zeros and every strobe and class output is 0. One clock after `start` is sampled high, `t_slot` equals 7'b0000001 (slot 0).
- R2: In slot 0, `bus_sel` is 3'b010 (program counter), `ar_load` is 1, and `ir_load`, `pc_inc` and `mem_read` are 0.
- R3: In slot 1, `bus_sel` is 3'b111 (memory), and `mem_read`, `ir_load` and `pc_inc` are 1, while `ar_load` is 0.
- R4: In slot 2, `bus_sel` is 3'b101 (instruction register), `ar_load` is 1, and `ind_flag` holds `ir_word[15]` from the following clock onward.
- R5: `d_line` is one-hot, with bit k set where k is the opcode `ir_word[14:12]`.
- R6: In slot 3, when the opcode is not 7 and `ind_flag` is 1, `mem_read` is 1, `bus_sel` is 3'b111 and `ar_load` is 1. When the opcode is not 7 and `ind_flag` is 0, all strobes are 0 and `bus_sel` is 3'b000.
- R7: In slot 3 exactly one class output is 1: `is_memref` when the opcode is 0 to 6, `is_regref` when the opcode is 7 and `ind_flag` is 0, and `is_io` when the opcode is 7 and `ind_flag` is 1. Outside slot 3 all three are 0.
- R8: While running, with no control request, the slot advances by one each clock. After slot 6 it returns to slot 0.
- R9: When `end_instr` is high in a running slot without `halt_req` or `start`, the next slot is slot 0.
- R10: When `halt_req` is high while running, `t_slot` becomes all zeros on the next clock, even if `end_instr` is also high. It stays all zeros until `start`.
- R11: When `start` is high in any state, including mid-instruction, the next slot is slot 0.
- R12: In slots 4 to 6, `bus_sel` is 3'b000 and all four strobes are 0.
- R13: `reg_op_single` is 1 only in slot 3 of a register-reference word, and there it is 1 exactly when `ir_word[11:0]` has a single set bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, leaves the sequencer idle |
| start | input | 1 | Clears the counter to slot 0 and enables stepping |
| halt_req | input | 1 | Stops the sequencer and freezes the counter |
| end_instr | input | 1 | Execution done, return to slot 0 next clock |
| ir_word | input | 16 | Current instruction register contents |
| t_slot | output | 7 | One-hot timing slot, all zeros when idle |
| d_line | output | 8 | Decoded opcode lines |
| ind_flag | output | 1 | Captured indirect mode bit |
| bus_sel | output | 3 | Common bus source select |
| ar_load | output | 1 | Address register load enable |
| ir_load | output | 1 | Instruction register load enable |
| pc_inc | output | 1 | Program counter increment enable |
| mem_read | output | 1 | Memory read enable |
| is_memref | output | 1 | Slot 3: memory-reference word |
| is_regref | output | 1 | Slot 3: register-reference word |
| is_io | output | 1 | Slot 3: input-output word |
| reg_op_single | output | 1 | Slot 3: register operation field has exactly one set bit |

## Verification
A corrupted counter shows up at once on `t_slot` and `bus_sel` in the same cycle, because every strobe is decoded from the held slot with no extra register stage. A stale or wrong mode flip-flop shows up one slot later. It appears at slot 3 as a wrong class output, or as a missing or spurious indirect address read. A run flag that is lost or stuck shows within one clock of a halt or start request, as a non-zero or all-zero timing vector.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int OPC_W = 3;
  localparam int BUS_W = 3;

  typedef enum logic [BUS_W-1:0] {
    BUS_NONE = 3'b000,
    BUS_PC   = 3'b010,
    BUS_IR   = 3'b101,
    BUS_MEM  = 3'b111
  } bus_src_e;
endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int SLOTS = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             halt_req,
  input  logic             end_instr,
  output logic [SLOTS-1:0] t_slot
);
  localparam int SC_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam logic [SC_W-1:0] LAST = SC_W'(SLOTS - 1);

  logic [SC_W-1:0] sc;
  logic            running;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc      <= '0;
      running <= 1'b0;
    end else if (start) begin
      sc      <= '0;
      running <= 1'b1;
    end else if (running) begin
      if (halt_req)
        running <= 1'b0;
      else if (end_instr || sc == LAST)
        sc <= '0;
      else
        sc <= sc + SC_W'(1);
    end
  end

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    assign t_slot[k] = running && (sc == SC_W'(k));
  end

  assert_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    running && !start && !halt_req && !end_instr && sc != LAST
    |=> sc == $past(sc) + SC_W'(1));

  assert_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    running && !start && !halt_req && sc == LAST |=> sc == '0);

  assert_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
    running && halt_req && !start |=> !running && sc == $past(sc));
endmodule

// File: rtl/op_decoder.sv
module op_decoder #(
  parameter int OPC_W = 3
) (
  input  logic [OPC_W-1:0]      opc,
  output logic [(1<<OPC_W)-1:0] d_line
);
  for (genvar k = 0; k < (1 << OPC_W); k++) begin : g_dec
    assign d_line[k] = (opc == OPC_W'(k));
  end

  always_comb begin
    assert_onehot_R5: assert ($onehot(d_line));
  end
endmodule

// File: rtl/strobe_gen.sv
module strobe_gen
  import seq_pkg::*;
#(
  parameter int SLOTS = 7,
  parameter int FLD_W = 12
) (
  input  logic [SLOTS-1:0] t_slot,
  input  logic             d_top,
  input  logic             ind_flag,
  input  logic [FLD_W-1:0] op_field,
  output bus_src_e         bus_sel,
  output logic             ar_load,
  output logic             ir_load,
  output logic             pc_inc,
  output logic             mem_read,
  output logic             is_memref,
  output logic             is_regref,
  output logic             is_io,
  output logic             reg_op_single
);
  logic indirect_go;

  assign indirect_go = t_slot[3] && !d_top && ind_flag;
  assign is_memref   = t_slot[3] && !d_top;
  assign is_regref   = t_slot[3] && d_top && !ind_flag;
  assign is_io       = t_slot[3] && d_top && ind_flag;
  assign reg_op_single = is_regref && $onehot(op_field);

  always_comb begin
    bus_sel  = BUS_NONE;
    ar_load  = 1'b0;
    ir_load  = 1'b0;
    pc_inc   = 1'b0;
    mem_read = 1'b0;
    if (t_slot[0]) begin
      bus_sel = BUS_PC;
      ar_load = 1'b1;
    end else if (t_slot[1]) begin
      bus_sel  = BUS_MEM;
      mem_read = 1'b1;
      ir_load  = 1'b1;
      pc_inc   = 1'b1;
    end else if (t_slot[2]) begin
      bus_sel = BUS_IR;
      ar_load = 1'b1;
    end else if (indirect_go) begin
      bus_sel  = BUS_MEM;
      mem_read = 1'b1;
      ar_load  = 1'b1;
    end
  end

  always_comb begin
    assert_class_R7: assert ($countones({is_memref, is_regref, is_io}) == (t_slot[3] ? 1 : 0));
    assert_pc_slot_R3: assert (!pc_inc || t_slot[1]);
  end
endmodule

// File: rtl/instr_cycle_sequencer.sv
module instr_cycle_sequencer
  import seq_pkg::*;
#(
  parameter int SLOTS  = 7,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              halt_req,
  input  logic              end_instr,
  input  logic [WORD_W-1:0] ir_word,
  output logic [SLOTS-1:0]  t_slot,
  output logic [7:0]        d_line,
  output logic              ind_flag,
  output logic [2:0]        bus_sel,
  output logic              ar_load,
  output logic              ir_load,
  output logic              pc_inc,
  output logic              mem_read,
  output logic              is_memref,
  output logic              is_regref,
  output logic              is_io,
  output logic              reg_op_single
);
  localparam int FLD_W = WORD_W - 1 - OPC_W;
  localparam int IND_B = WORD_W - 1;

  bus_src_e bus_src;

  seq_timer #(.SLOTS(SLOTS)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .halt_req (halt_req),
    .end_instr(end_instr),
    .t_slot   (t_slot)
  );

  op_decoder #(.OPC_W(OPC_W)) u_dec (
    .opc   (ir_word[IND_B-1 -: OPC_W]),
    .d_line(d_line)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ind_flag <= 1'b0;
    else if (t_slot[2]) ind_flag <= ir_word[IND_B];
  end

  strobe_gen #(.SLOTS(SLOTS), .FLD_W(FLD_W)) u_strb (
    .t_slot       (t_slot),
    .d_top        (d_line[7]),
    .ind_flag     (ind_flag),
    .op_field     (ir_word[FLD_W-1:0]),
    .bus_sel      (bus_src),
    .ar_load      (ar_load),
    .ir_load      (ir_load),
    .pc_inc       (pc_inc),
    .mem_read     (mem_read),
    .is_memref    (is_memref),
    .is_regref    (is_regref),
    .is_io        (is_io),
    .reg_op_single(reg_op_single)
  );

  assign bus_sel = bus_src;

  assert_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> t_slot == SLOTS'(1));

  assert_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|t_slot) && end_instr && !halt_req && !start |=> t_slot == SLOTS'(1));

  assert_halt_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|t_slot) && halt_req && !start |=> t_slot == '0);

  assert_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    t_slot[2] |=> ind_flag == $past(ir_word[IND_B]));

  assert_fetch_after_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ir_load && !start && !halt_req && !end_instr |=> t_slot[2]);

  assert_ar_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ar_load |-> t_slot[0] || t_slot[2] || t_slot[3]);

  assert_indirect_R6: assert property (@(posedge clk) disable iff (!rst_n)
    t_slot[3] && !d_line[7] && ind_flag |-> mem_read && ar_load);
endmodule

// File: tb/instr_cycle_sequencer_test.sv
module instr_cycle_sequencer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        halt_req = 1'b0;
  logic        end_instr = 1'b0;
  logic [15:0] ir_word = 16'h0000;
  logic [6:0]  t_slot;
  logic [7:0]  d_line;
  logic        ind_flag;
  logic [2:0]  bus_sel;
  logic        ar_load, ir_load, pc_inc, mem_read;
  logic        is_memref, is_regref, is_io, reg_op_single;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  instr_cycle_sequencer uut (
    .clk(clk), .rst_n(rst_n), .start(start), .halt_req(halt_req),
    .end_instr(end_instr), .ir_word(ir_word), .t_slot(t_slot),
    .d_line(d_line), .ind_flag(ind_flag), .bus_sel(bus_sel),
    .ar_load(ar_load), .ir_load(ir_load), .pc_inc(pc_inc),
    .mem_read(mem_read), .is_memref(is_memref), .is_regref(is_regref),
    .is_io(is_io), .reg_op_single(reg_op_single)
  );

  // strobe pack: {bus_sel, ar_load, ir_load, pc_inc, mem_read}
  localparam logic [6:0] S_T0  = 7'b010_1000;
  localparam logic [6:0] S_T1  = 7'b111_0111;
  localparam logic [6:0] S_T2  = 7'b101_1000;
  localparam logic [6:0] S_IND = 7'b111_1001;
  localparam logic [6:0] S_OFF = 7'b000_0000;

  // vector: {ir_word, class {memref,regref,io}, indirect, single}
  localparam logic [20:0] VEC [8] = '{
    {16'h1234, 3'b100, 1'b0, 1'b0},
    {16'h9ABC, 3'b100, 1'b1, 1'b0},
    {16'h7800, 3'b010, 1'b0, 1'b1},
    {16'h7003, 3'b010, 1'b0, 1'b0},
    {16'hF400, 3'b001, 1'b0, 1'b0},
    {16'h6FFF, 3'b100, 1'b0, 1'b0},
    {16'hE001, 3'b100, 1'b1, 1'b0},
    {16'h0000, 3'b100, 1'b0, 1'b0}
  };

  function automatic logic [6:0] strobes();
    return {bus_sel, ar_load, ir_load, pc_inc, mem_read};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_start();
    start = 1'b1;
    tick();
    start = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    tick();
    tick();
    // R1: idle after reset
    chk("R1 idle slot", 32'(t_slot), 32'h0);
    chk("R1 idle strobes", 32'(strobes()), 32'(S_OFF));
    chk("R1 idle class", 32'({is_memref, is_regref, is_io}), 32'h0);
    do_start();
    chk("R1 start slot0", 32'(t_slot), 32'h1);

    // Table walk: one instruction per vector, execution ends in slot 4
    for (int v = 0; v < 8; v++) begin
      logic [15:0] w;
      logic [2:0]  cls;
      logic        ind, single;
      {w, cls, ind, single} = VEC[v];
      chk("R2 slot0", 32'(t_slot), 32'h1);
      chk("R2 fetch addr", 32'(strobes()), 32'(S_T0));
      tick();
      chk("R3 slot1", 32'(t_slot), 32'h2);
      chk("R3 fetch read", 32'(strobes()), 32'(S_T1));
      ir_word = w;
      tick();
      chk("R4 decode", 32'(strobes()), 32'(S_T2));
      chk("R5 decode lines", 32'(d_line), 32'(8'd1 << w[14:12]));
      chk("R7 class before slot3", 32'({is_memref, is_regref, is_io}), 32'h0);
      tick();
      chk("R4 mode flag", 32'(ind_flag), 32'(w[15]));
      chk("R7 class", 32'({is_memref, is_regref, is_io}), 32'(cls));
      chk("R6 indirect strobes", 32'(strobes()), 32'(ind ? S_IND : S_OFF));
      chk("R13 single op", 32'(reg_op_single), 32'(single));
      tick();
      chk("R12 exec slot", 32'(strobes()), 32'(S_OFF));
      chk("R13 outside slot3", 32'(reg_op_single), 32'h0);
      end_instr = 1'b1;
      tick();
      end_instr = 1'b0;
      chk("R9 end to slot0", 32'(t_slot), 32'h1);
    end

    // R8: free run through every slot and wrap
    for (int s = 1; s < 7; s++) begin
      tick();
      chk("R8 advance", 32'(t_slot), 32'(7'd1 << s));
      if (s >= 4) chk("R12 late slot", 32'(strobes()), 32'(S_OFF));
    end
    tick();
    chk("R8 wrap", 32'(t_slot), 32'h1);

    // R10: halt in slot 5 freezes until start
    for (int s = 0; s < 5; s++) tick();
    chk("R8 reach slot5", 32'(t_slot), 32'h20);
    halt_req = 1'b1;
    tick();
    halt_req = 1'b0;
    chk("R10 halted", 32'(t_slot), 32'h0);
    tick(); tick(); tick();
    chk("R10 stays halted", 32'(t_slot), 32'h0);
    chk("R10 no strobes", 32'(strobes()), 32'(S_OFF));
    do_start();
    chk("R11 restart", 32'(t_slot), 32'h1);

    // R10: halt wins over end in slot 4
    for (int s = 0; s < 4; s++) tick();
    halt_req = 1'b1;
    end_instr = 1'b1;
    tick();
    halt_req = 1'b0;
    end_instr = 1'b0;
    chk("R10 halt over end", 32'(t_slot), 32'h0);
    do_start();

    // R11: start in slot 2 restarts fetch
    tick(); tick();
    chk("R4 at slot2", 32'(t_slot), 32'h4);
    do_start();
    chk("R11 mid restart", 32'(t_slot), 32'h1);
    chk("R11 fetch strobes", 32'(strobes()), 32'(S_T0));

    // R9: end in slot 3 (register word finishes early)
    tick();
    ir_word = 16'h7400;
    tick(); tick();
    chk("R7 regref", 32'({is_memref, is_regref, is_io}), 32'b010);
    end_instr = 1'b1;
    tick();
    end_instr = 1'b0;
    chk("R9 end at slot3", 32'(t_slot), 32'h1);

    // R1: reset mid-run returns to idle
    rst_n = 1'b0;
    tick();
    rst_n = 1'b1;
    tick();
    chk("R1 reset idle", 32'(t_slot), 32'h0);
    chk("R1 reset mode", 32'(ind_flag), 32'h0);

    finish_run();
  end
endmodule